// File: doc/BRIEF.md
# I/O Page Access Router

This block stands between the bus masters of a small backplane system (the processor and any DMA device) and the top page of the address space that holds peripheral and processor registers. Each request carries an address, a write flag, a flag saying whether a DMA device made it, and an I/O-page strobe. A static `bus_wide` pin picks how the I/O page is found. In narrow mode the address is 18 bits and the page is found from the address alone. In wide mode the address is 22 bits and the page is marked by the strobe.

Inside the I/O page, the low 13 bits are looked up in a parameter table of offset ranges. Each range is flagged as processor-internal or external. Internal registers answer only the processor, so a DMA request to one ends in a bus timeout and no select is driven. External and unclaimed offsets go to the device side and wait for an acknowledge. If none comes within the timeout window, the access ends in a timeout. Processor-side 16-to-18-bit extension happens before this block, so processor addresses arrive already extended.

Requests use a valid/ready handshake. `req_ready` is high only while no access is in flight. A master holds `req_valid` and its fields steady until the cycle in which both are high. That edge accepts the request, and the router takes no other request until this one has ended.

Top module: `iopage_router`

## Requirements
- R1: With `bus_wide`=0, a request is an I/O page access exactly when address bits 17:13 are all ones. Bits 21:18 and `req_iostrobe` have no effect.
- R2: With `bus_wide`=1, a request is an I/O page access exactly when `req_iostrobe` is 1. Only address bits 12:0 choose the register.
- R3: A non-I/O-page request drives `sel_mem` and `done` together for exactly one cycle. That cycle is the one after acceptance.
- R4: A processor request (`req_dma`=0) whose offset falls in an internal range drives `sel_int` and `done` for one cycle, in the cycle after acceptance. The default internal ranges are 0x1FFE–0x1FFF (status word), 0x1FA0–0x1FBF (memory management) and 0x0080–0x00FF (DMA address map).
- R5: A DMA request (`req_dma`=1) to an internal range drives no select. It drives `timeout` for one cycle in the cycle after acceptance, and `done` stays low.
- R6: A request to an external range drives `sel_ext` from the cycle after acceptance through the cycle in which `ext_ack` is 1. `done` is high in that acknowledge cycle. The default external ranges are 0x1F00–0x1F3F and 0x0400–0x04FF, and processor and DMA masters are treated alike.
- R7: If `ext_ack` has not arrived by the 16th cycle of `sel_ext`, that cycle raises `timeout` and `sel_ext` drops after it. An acknowledge in the 16th cycle still yields `done`.
- R8: An I/O page offset that matches no range is treated as external. With no device to answer, it ends in `timeout` after 16 cycles.
- R9: Each accepted request yields exactly one `done` or `timeout` pulse, never both. `req_ready` is high only when idle, so a request held under back-pressure is taken the cycle after the previous one ends.
- R10: `acc_addr` and `acc_write` present the accepted request's address and write flag while any select is high.
- R11: `ext_ack` while no external access is in flight produces no `done`, no `timeout` and no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wide | input | 1 | 0: 18-bit narrow mode, 1: 22-bit wide mode with strobe |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle and able to accept |
| req_addr | input | 22 | Request address |
| req_write | input | 1 | 1 = write |
| req_dma | input | 1 | 1 = DMA master, 0 = processor |
| req_iostrobe | input | 1 | I/O page strobe (wide mode only) |
| ext_ack | input | 1 | External device acknowledge |
| sel_mem | output | 1 | Memory select |
| sel_int | output | 1 | Processor-internal register select |
| sel_ext | output | 1 | External device select |
| acc_addr | output | 22 | Address of the access in flight |
| acc_write | output | 1 | Write flag of the access in flight |
| done | output | 1 | Access completed |
| timeout | output | 1 | Non-existent-memory / bus timeout |

## Verification
The bench builds the router with its default parameters: a 22-bit address, an 18-bit narrow space, a timeout of 16 cycles and the five-entry range table listed above. With those values the bench reaches several boundary cases. It checks the exact 16th-cycle timeout edge and an acknowledge landing on that same edge. It drives addresses with high bits set in narrow mode, and offset-only decoding in wide mode. It checks the DMA fault on each internal range class, an unclaimed offset, and a request stalled behind a live external access.

// File: rtl/iopr_pkg.sv
package iopr_pkg;
  localparam int OFS_W = 13;

  typedef enum logic [1:0] {
    TGT_MEM   = 2'd0,
    TGT_INT   = 2'd1,
    TGT_EXT   = 2'd2,
    TGT_FAULT = 2'd3
  } target_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHORT = 2'd1,
    ST_EXT   = 2'd2,
    ST_FAULT = 2'd3
  } state_e;
endpackage

// File: rtl/iopr_classify.sv
module iopr_classify
  import iopr_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int NARROW_W   = 18,
  parameter int NUM_RANGES = 5,
  parameter logic [NUM_RANGES*OFS_W-1:0] RANGE_LO =
    {13'h0400, 13'h1F00, 13'h0080, 13'h1FA0, 13'h1FFE},
  parameter logic [NUM_RANGES*OFS_W-1:0] RANGE_HI =
    {13'h04FF, 13'h1F3F, 13'h00FF, 13'h1FBF, 13'h1FFF},
  parameter logic [NUM_RANGES-1:0] RANGE_INT = 5'b00111
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iostrobe,
  input  logic              wide,
  input  logic              dma,
  output target_e           target
);
  logic [OFS_W-1:0]      offset;
  logic                  io_narrow;
  logic                  io_hit;
  logic [NUM_RANGES-1:0] hit;
  logic                  claimed;
  logic                  is_int;

  assign offset    = addr[OFS_W-1:0];
  assign io_narrow = &addr[NARROW_W-1:OFS_W];
  assign io_hit    = wide ? iostrobe : io_narrow;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    localparam logic [OFS_W-1:0] LO = RANGE_LO[g*OFS_W +: OFS_W];
    localparam logic [OFS_W-1:0] HI = RANGE_HI[g*OFS_W +: OFS_W];
    assign hit[g] = (offset >= LO) && (offset <= HI);
  end

  // lowest index wins when ranges overlap
  always_comb begin
    claimed = 1'b0;
    is_int  = 1'b0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        claimed = 1'b1;
        is_int  = RANGE_INT[i];
      end
    end
  end

  always_comb begin
    if (!io_hit)                target = TGT_MEM;
    else if (claimed && is_int) target = dma ? TGT_FAULT : TGT_INT;
    else                        target = TGT_EXT;
  end
endmodule

// File: rtl/iopr_timer.sv
module iopr_timer #(
  parameter int TMO_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  // the router leaves the external state on expiry, so expiry never repeats
  p_expiry_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);
endmodule

// File: rtl/iopage_router.sv
module iopage_router
  import iopr_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int NARROW_W   = 18,
  parameter int TMO_CYCLES = 16,
  parameter int NUM_RANGES = 5,
  parameter logic [NUM_RANGES*OFS_W-1:0] RANGE_LO =
    {13'h0400, 13'h1F00, 13'h0080, 13'h1FA0, 13'h1FFE},
  parameter logic [NUM_RANGES*OFS_W-1:0] RANGE_HI =
    {13'h04FF, 13'h1F3F, 13'h00FF, 13'h1FBF, 13'h1FFF},
  parameter logic [NUM_RANGES-1:0] RANGE_INT = 5'b00111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_dma,
  input  logic              req_iostrobe,
  input  logic              ext_ack,
  output logic              sel_mem,
  output logic              sel_int,
  output logic              sel_ext,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_write,
  output logic              done,
  output logic              timeout
);
  target_e           tgt;
  state_e            state_q;
  logic              short_int_q;
  logic              dma_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic              expired;
  logic              accept;

  iopr_classify #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .NUM_RANGES(NUM_RANGES),
    .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI), .RANGE_INT(RANGE_INT)
  ) u_classify (
    .addr(req_addr), .iostrobe(req_iostrobe), .wide(bus_wide),
    .dma(req_dma), .target(tgt)
  );

  iopr_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_EXT), .expired(expired)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      short_int_q <= 1'b0;
      dma_q       <= 1'b0;
      addr_q      <= '0;
      write_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q      <= req_addr;
          write_q     <= req_write;
          dma_q       <= req_dma;
          short_int_q <= (tgt == TGT_INT);
          unique case (tgt)
            TGT_MEM, TGT_INT: state_q <= ST_SHORT;
            TGT_EXT:          state_q <= ST_EXT;
            default:          state_q <= ST_FAULT;
          endcase
        end
        ST_SHORT: state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        ST_EXT:   if (ext_ack || expired) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_mem   = (state_q == ST_SHORT) && !short_int_q;
  assign sel_int   = (state_q == ST_SHORT) &&  short_int_q;
  assign sel_ext   = (state_q == ST_EXT);
  assign acc_addr  = addr_q;
  assign acc_write = write_q;
  assign done      = (state_q == ST_SHORT) || (sel_ext && ext_ack);
  assign timeout   = (state_q == ST_FAULT) || (sel_ext && !ext_ack && expired);

  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_mem, sel_int, sel_ext}));

  p_single_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> req_ready);

  p_dma_no_int_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_int |-> !dma_q);

  p_ext_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && !done && !timeout) |=> sel_ext);

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && !done && !timeout) |=> ($stable(acc_addr) && $stable(acc_write)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!done && !timeout));
endmodule

// File: tb/iopage_router_tb_top.sv
`timescale 1ns/1ps
module iopage_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wide = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_dma = 1'b0;
  logic        req_iostrobe = 1'b0;
  logic        ext_ack = 1'b0;
  logic        sel_mem, sel_int, sel_ext;
  logic [21:0] acc_addr;
  logic        acc_write, done, timeout;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  iopage_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_dma(req_dma), .req_iostrobe(req_iostrobe),
    .ext_ack(ext_ack), .sel_mem(sel_mem), .sel_int(sel_int), .sel_ext(sel_ext),
    .acc_addr(acc_addr), .acc_write(acc_write), .done(done), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Runs one access. Cycle 1 is the first cycle after acceptance.
  task automatic run_acc(input logic [21:0] a, input logic w, input logic d,
                         input logic s, input int ack_at,
                         output int end_cyc, output logic f_done,
                         output logic f_tmo, output logic [2:0] f_sel,
                         output logic [21:0] f_addr, output logic f_wr,
                         output logic [2:0] after);
    int cyc;
    @(negedge clk);
    req_addr = a; req_write = w; req_dma = d; req_iostrobe = s; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    ext_ack = (ack_at == 1);
    #1;
    f_sel = {sel_mem, sel_int, sel_ext};
    f_addr = acc_addr;
    f_wr = acc_write;
    while (!(done || timeout) && cyc < 40) begin
      @(negedge clk);
      cyc++;
      ext_ack = (ack_at == cyc);
      #1;
    end
    f_done = done; f_tmo = timeout; end_cyc = cyc;
    @(negedge clk);
    ext_ack = 1'b0;
    #1;
    after = {req_ready, done || timeout, sel_mem | sel_int | sel_ext};
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    chk({sel_mem, sel_int, sel_ext} == 3'b000, "R9", "selects after reset",
        {sel_mem, sel_int, sel_ext}, 0);
    chk({done, timeout} == 2'b00, "R9", "end pulses after reset", {done, timeout}, 0);
  endtask

  task automatic t_short(input string req, input logic wide_m, input logic [21:0] a,
                         input logic s, input logic [2:0] exp_sel);
    int e; logic fd, ft, fw; logic [2:0] fs, af; logic [21:0] fa;
    bus_wide = wide_m;
    run_acc(a, 1'b0, 1'b0, s, 0, e, fd, ft, fs, fa, fw, af);
    chk(fs == exp_sel, req, "select {mem,int,ext}", fs, exp_sel);
    chk(e == 1 && fd && !ft, req, "done in cycle 1", e, 1);
    chk(fa == a, "R10", "acc_addr during select", fa, a);
    chk(af == 3'b100, "R9", "idle and single end after access", af, 3'b100);
  endtask

  task automatic t_dma_fault(input logic [21:0] a);
    int e; logic fd, ft, fw; logic [2:0] fs, af; logic [21:0] fa;
    bus_wide = 1'b0;
    run_acc(a, 1'b1, 1'b1, 1'b0, 0, e, fd, ft, fs, fa, fw, af);
    chk(fs == 3'b000, "R5", "no select on DMA to internal", fs, 0);
    chk(e == 1 && ft && !fd, "R5", "timeout in cycle 1", e, 1);
    chk(af == 3'b100, "R9", "idle after fault", af, 3'b100);
  endtask

  task automatic t_ext(input string req, input logic [21:0] a, input logic w,
                       input logic d, input int ack_at, input int exp_end,
                       input logic exp_done);
    int e; logic fd, ft, fw; logic [2:0] fs, af; logic [21:0] fa;
    bus_wide = 1'b0;
    run_acc(a, w, d, 1'b0, ack_at, e, fd, ft, fs, fa, fw, af);
    chk(fs == 3'b001, req, "sel_ext in cycle 1", fs, 3'b001);
    chk(e == exp_end, req, "end cycle", e, exp_end);
    chk(fd == exp_done && ft == !exp_done, req, "done/timeout kind",
        {fd, ft}, {exp_done, !exp_done});
    chk(fa == a && fw == w, "R10", "acc_addr/acc_write", {fw, fa}, {w, a});
    chk(af == 3'b100, "R7", "sel_ext dropped after end", af, 3'b100);
  endtask

  task automatic t_backpressure();
    int waited = 0;
    bus_wide = 1'b0;
    @(negedge clk);
    req_addr = 22'h3FF20; req_write = 1'b0; req_dma = 1'b0; req_valid = 1'b1;
    @(negedge clk);  // cycle 1 of the external access
    req_addr = 22'h00500; req_write = 1'b1;  // second request, held
    @(negedge clk);  // cycle 2
    #1;
    chk(req_ready == 1'b0 && sel_ext, "R9", "ready low while busy", req_ready, 0);
    @(negedge clk); ext_ack = 1'b1; #1;  // cycle 3
    chk(done == 1'b1, "R6", "done on ack", done, 1);
    @(negedge clk); ext_ack = 1'b0; #1;  // idle, second request accepted at next edge
    chk(req_ready == 1'b1, "R9", "ready after end", req_ready, 1);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(sel_mem && done && acc_addr == 22'h00500 && acc_write, "R9",
        "held request served next", {sel_mem, done, acc_addr}, {2'b11, 22'h00500});
    @(negedge clk); #1;
    waited = req_ready;
    chk(waited == 1, "R9", "idle after second", waited, 1);
  endtask

  task automatic t_stray_ack();
    int e; logic fd, ft, fw; logic [2:0] fs, af; logic [21:0] fa;
    logic seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ext_ack = 1'b1; #1;
      seen = seen | done | timeout | sel_mem | sel_int | sel_ext | !req_ready;
    end
    @(negedge clk); ext_ack = 1'b0;
    chk(seen == 1'b0, "R11", "stray ack produced activity", seen, 0);
    bus_wide = 1'b0;
    run_acc(22'h01234, 1'b0, 1'b0, 1'b0, 0, e, fd, ft, fs, fa, fw, af);
    chk(fs == 3'b100 && e == 1 && fd, "R11", "memory access after stray ack",
        fs, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    // R1 narrow mode
    t_short("R3", 1'b0, 22'h01000, 1'b0, 3'b100);
    t_short("R1", 1'b0, 22'h3C1000, 1'b1, 3'b100);
    t_short("R1", 1'b0, 22'h3FFFFE, 1'b0, 3'b010);
    t_short("R4", 1'b0, 22'h3FFFE, 1'b0, 3'b010);
    t_short("R4", 1'b0, 22'h3FFA4, 1'b0, 3'b010);
    t_short("R4", 1'b0, 22'h3E080, 1'b0, 3'b010);
    // R2 wide mode
    t_short("R2", 1'b1, 22'h3FFFFE, 1'b0, 3'b100);
    t_short("R2", 1'b1, 22'h001FFE, 1'b1, 3'b010);
    t_short("R2", 1'b1, 22'h2A1FA4, 1'b1, 3'b010);
    // R5 DMA to internal ranges
    t_dma_fault(22'h3FFFE);
    t_dma_fault(22'h3FFA0);
    t_dma_fault(22'h3E0FF);
    // R6 external with acknowledge
    t_ext("R6", 22'h3FF10, 1'b1, 1'b0, 3, 3, 1'b1);
    t_ext("R6", 22'h3E400, 1'b0, 1'b1, 1, 1, 1'b1);
    // R7 timeout edge
    t_ext("R7", 22'h3FF3F, 1'b0, 1'b0, 0, 16, 1'b0);
    t_ext("R7", 22'h3FF00, 1'b1, 1'b1, 16, 16, 1'b1);
    // R8 unclaimed offsets
    t_ext("R8", 22'h3F000, 1'b0, 1'b0, 0, 16, 1'b0);
    t_ext("R8", 22'h3F000, 1'b1, 1'b1, 0, 16, 1'b0);
    t_backpressure();
    t_stray_ack();
    report();
  end

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end
endmodule